// File: doc/BRIEF.md
# Nested-Length DMA Address Sequencer

This block sequences the addresses and lengths for a single DMA channel. A transfer is organised in three nested levels: fragments make up a block, and blocks make up a transaction. Software loads the configuration with a `start` pulse while the block is idle. That configuration holds two 36-bit addresses, a data width for each side, a step for each side, an optional fixed-address mode, three byte lengths and a 2-bit request mode. Each later `req` pulse releases one unit of work, and the request mode picks the size of that unit: one fragment, one block or the whole transaction.

While a unit is running, the block presents one beat command per cycle on `beat_vld`. Each command carries a read address, a write address and a size code for each side. A beat is accepted in any cycle where `beat_rdy` is high. In the cycle that accepts the last beat of a fragment, a block or the transaction, the matching done pulse is raised combinationally. When the unit is finished, the sequencer waits for the next request. When the transaction length is used up, it returns to idle. A configuration that cannot be run produces a single error pulse and no beats.

Top module: `dma_seq_core`

## Requirements
- R1: After reset the block is idle: `busy`, `beat_vld`, `beat_last`, `cfg_err` and all three done outputs are 0.
- R2: `start` while idle latches the configuration. The request mode is `frag_cfg[25:24]`, the source width is `[31:30]`, the destination width is `[29:28]`, the fixed select is `[21]`, the fixed enable is `[20]` and the fragment length is `[16:0]`. The source step is `step_cfg[15:0]` and the destination step is `step_cfg[31:16]`. Each address is `{*_hi, *_lo}`. `busy` rises and the block waits for a request. A `start` while busy is ignored, and the configuration already latched stays in use.
- R3: A zero fragment, block or transaction length, a width code of 3 on either side, or request mode 3 raises `cfg_err` for one cycle, one cycle after `start`. The block stays idle and issues no beats.
- R4: Each beat moves 2^(source width code) bytes (0 is a byte, 1 a halfword, 2 a word). `rd_size` and `wr_size` show the source and destination width codes.
- R5: After each accepted beat, each address advances by its step, modulo 2^36. While `beat_vld` is high and `beat_rdy` is low, the command holds.
- R6: With fixed enable set, select 0 holds the read address constant and select 1 holds the write address constant. The other side still steps.
- R7: A beat is the last of its fragment when the remaining fragment bytes are no more than the beat bytes, or when it ends the block. `beat_last` flags that beat, `frag_done` pulses in the cycle it is accepted, and the fragment counter reloads.
- R8: A block ends the same way, using the block counter, or when the transaction ends. `blk_done` pulses in the accepting cycle, and the block counter reloads.
- R9: The beat that uses up the transaction length pulses `trn_done`, `blk_done` and `frag_done` together, and `busy` is 0 in the next cycle.
- R10: Request mode 0 runs one fragment per request, mode 1 one block, and mode 2 the whole transaction. Between units no beat is issued. A `req` while idle or while beats are running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the configuration (idle only) |
| req | input | 1 | Release one unit of work |
| frag_cfg | input | 32 | Mode, widths, fixed-address control, fragment length |
| blk_len | input | 17 | Block length in bytes |
| trn_len | input | 28 | Transaction length in bytes |
| step_cfg | input | 32 | Destination step [31:16], source step [15:0] |
| src_lo | input | 32 | Source address bits 31:0 |
| dst_lo | input | 32 | Destination address bits 31:0 |
| src_hi | input | 4 | Source address bits 35:32 (wrap register bits 31:28) |
| dst_hi | input | 4 | Destination address bits 35:32 (wrap register bits 31:28) |
| beat_rdy | input | 1 | Beat command accepted |
| beat_vld | output | 1 | Beat command valid |
| rd_addr | output | 36 | Read address of the beat |
| wr_addr | output | 36 | Write address of the beat |
| rd_size | output | 2 | Source width code |
| wr_size | output | 2 | Destination width code |
| beat_last | output | 1 | Beat closes at least a fragment |
| frag_done | output | 1 | Fragment completed this cycle |
| blk_done | output | 1 | Block completed this cycle |
| trn_done | output | 1 | Transaction completed this cycle |
| cfg_err | output | 1 | Configuration rejected |
| busy | output | 1 | Configuration loaded, transaction not finished |

## Verification
The beat that closes a unit of work and a new `req` can land in the same cycle. The bench provokes this by randomly raising `req` during running beats, including the completing beat. It then expects the very next cycle to show no beat, and beats to resume only after a later request. Fragment, block and transaction completion also coincide on shared final beats. Cases with a block shorter than its fragment, and with a transaction that is not a multiple of the beat size, are judged against a model that reloads each counter independently.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        RM_FRAG = 2'd0,
        RM_BLK  = 2'd1,
        RM_TRN  = 2'd2,
        RM_LIST = 2'd3
    } req_mode_e;

    localparam int CFG_SW_HI   = 31;
    localparam int CFG_DW_HI   = 29;
    localparam int CFG_MODE_HI = 25;
    localparam int CFG_FSEL    = 21;
    localparam int CFG_FEN     = 20;
    localparam logic [1:0] WIDTH_BAD = 2'd3;
endpackage

// File: rtl/dma_seq_len.sv
module dma_seq_len #(
    parameter int W = 17
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] bytes,
    input  logic         take,
    input  logic         restart,
    output logic         last,
    output logic [W-1:0] nxt
);
    assign last = (rem <= bytes);

    always_comb begin
        if (take && restart) begin
            nxt = reload;
        end else if (take) begin
            nxt = rem - bytes;
        end else begin
            nxt = rem;
        end
    end
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int AW = 36,
    parameter int SW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [SW-1:0] step,
    input  logic          take,
    input  logic          hold,
    output logic [AW-1:0] nxt
);
    assign nxt = (take && !hold) ? cur + AW'(step) : cur;
endmodule

// File: rtl/dma_seq_core.sv
module dma_seq_core
    import dma_seq_pkg::*;
#(
    parameter int LO_W = 32,
    parameter int AW   = 36,
    parameter int FW   = 17,
    parameter int BW   = 17,
    parameter int TW   = 28,
    parameter int SW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               req,
    input  logic [31:0]        frag_cfg,
    input  logic [BW-1:0]      blk_len,
    input  logic [TW-1:0]      trn_len,
    input  logic [2*SW-1:0]    step_cfg,
    input  logic [LO_W-1:0]    src_lo,
    input  logic [LO_W-1:0]    dst_lo,
    input  logic [AW-LO_W-1:0] src_hi,
    input  logic [AW-LO_W-1:0] dst_hi,
    input  logic               beat_rdy,
    output logic               beat_vld,
    output logic [AW-1:0]      rd_addr,
    output logic [AW-1:0]      wr_addr,
    output logic [1:0]         rd_size,
    output logic [1:0]         wr_size,
    output logic               beat_last,
    output logic               frag_done,
    output logic               blk_done,
    output logic               trn_done,
    output logic               cfg_err,
    output logic               busy
);
    localparam int NSIDE = 2;

    typedef struct packed {
        seq_st_e         st;
        req_mode_e       mode;
        logic [1:0]      sw;
        logic [1:0]      dw;
        logic            fix_en;
        logic            fix_sel;
        logic [SW-1:0]   s_step;
        logic [SW-1:0]   d_step;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [FW-1:0]   f_len;
        logic [FW-1:0]   f_rem;
        logic [BW-1:0]   b_len;
        logic [BW-1:0]   b_rem;
        logic [TW-1:0]   t_rem;
        logic            err;
    } seq_t;

    seq_t q, d;

    logic          acc;
    logic [TW-1:0] bb;
    logic          f_last, b_last, t_last;
    logic          f_end, b_end, unit_end;
    logic [FW-1:0] f_nxt;
    logic [BW-1:0] b_nxt;
    logic [TW-1:0] t_nxt;
    logic          cfg_bad;
    logic          unused_cfg_bits;

    assign unused_cfg_bits = ^{frag_cfg[27:26], frag_cfg[23:22], frag_cfg[19:FW]};

    assign acc   = (q.st == ST_RUN) && beat_rdy;
    assign bb    = TW'(1) << q.sw;
    assign f_end = f_last || b_last || t_last;
    assign b_end = b_last || t_last;

    always_comb begin
        case (q.mode)
            RM_FRAG: unit_end = f_end;
            RM_BLK:  unit_end = b_end;
            default: unit_end = t_last;
        endcase
    end

    dma_seq_len #(.W(FW)) u_frag (
        .rem(q.f_rem), .reload(q.f_len), .bytes(FW'(bb)),
        .take(acc), .restart(f_end), .last(f_last), .nxt(f_nxt)
    );
    dma_seq_len #(.W(BW)) u_blk (
        .rem(q.b_rem), .reload(q.b_len), .bytes(BW'(bb)),
        .take(acc), .restart(b_end), .last(b_last), .nxt(b_nxt)
    );
    dma_seq_len #(.W(TW)) u_trn (
        .rem(q.t_rem), .reload(q.t_rem), .bytes(bb),
        .take(acc), .restart(1'b0), .last(t_last), .nxt(t_nxt)
    );

    logic [AW-1:0] a_cur  [NSIDE];
    logic [AW-1:0] a_nxt  [NSIDE];
    logic [SW-1:0] a_step [NSIDE];
    logic          a_hold [NSIDE];

    assign a_cur[0]  = q.src;
    assign a_cur[1]  = q.dst;
    assign a_step[0] = q.s_step;
    assign a_step[1] = q.d_step;
    assign a_hold[0] = q.fix_en && !q.fix_sel;
    assign a_hold[1] = q.fix_en && q.fix_sel;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_seq_addr #(.AW(AW), .SW(SW)) u_addr (
            .cur(a_cur[s]), .step(a_step[s]), .take(acc),
            .hold(a_hold[s]), .nxt(a_nxt[s])
        );
    end

    assign cfg_bad = (frag_cfg[FW-1:0] == '0) || (blk_len == '0) || (trn_len == '0)
                  || (frag_cfg[CFG_SW_HI -: 2] == WIDTH_BAD)
                  || (frag_cfg[CFG_DW_HI -: 2] == WIDTH_BAD)
                  || (frag_cfg[CFG_MODE_HI -: 2] == RM_LIST);

    always_comb begin
        d     = q;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (cfg_bad) begin
                        d.err = 1'b1;
                    end else begin
                        d.st      = ST_WAIT;
                        d.mode    = req_mode_e'(frag_cfg[CFG_MODE_HI -: 2]);
                        d.sw      = frag_cfg[CFG_SW_HI -: 2];
                        d.dw      = frag_cfg[CFG_DW_HI -: 2];
                        d.fix_en  = frag_cfg[CFG_FEN];
                        d.fix_sel = frag_cfg[CFG_FSEL];
                        d.s_step  = step_cfg[SW-1:0];
                        d.d_step  = step_cfg[2*SW-1:SW];
                        d.src     = {src_hi, src_lo};
                        d.dst     = {dst_hi, dst_lo};
                        d.f_len   = frag_cfg[FW-1:0];
                        d.f_rem   = frag_cfg[FW-1:0];
                        d.b_len   = blk_len;
                        d.b_rem   = blk_len;
                        d.t_rem   = trn_len;
                    end
                end
            end
            ST_WAIT: begin
                if (req) begin
                    d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (acc) begin
                    d.src   = a_nxt[0];
                    d.dst   = a_nxt[1];
                    d.f_rem = f_nxt;
                    d.b_rem = b_nxt;
                    d.t_rem = t_nxt;
                    if (t_last) begin
                        d.st = ST_IDLE;
                    end else if (unit_end) begin
                        d.st = ST_WAIT;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign beat_vld  = (q.st == ST_RUN);
    assign rd_addr   = q.src;
    assign wr_addr   = q.dst;
    assign rd_size   = q.sw;
    assign wr_size   = q.dw;
    assign beat_last = beat_vld && f_end;
    assign frag_done = acc && f_end;
    assign blk_done  = acc && b_end;
    assign trn_done  = acc && t_last;
    assign cfg_err   = q.err;
    assign busy      = (q.st != ST_IDLE);
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int AW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          beat_rdy,
    input logic          beat_vld,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] wr_addr,
    input logic          beat_last,
    input logic          frag_done,
    input logic          blk_done,
    input logic          trn_done,
    input logic          cfg_err,
    input logic          busy
);
    AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        frag_done |-> (beat_vld && beat_rdy && beat_last)); // R7
    AST_BLK_CLOSES_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> frag_done); // R8
    AST_TRN_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        trn_done |-> (blk_done && frag_done)); // R9
    AST_TRN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trn_done |=> !busy); // R9
    AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !beat_rdy) |=> (beat_vld && $stable(rd_addr) && $stable(wr_addr))); // R5
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !beat_vld)); // R3
    AST_ERR_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(start)); // R3
endmodule

bind dma_seq_core dma_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_rdy(beat_rdy),
    .beat_vld(beat_vld), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .beat_last(beat_last), .frag_done(frag_done), .blk_done(blk_done),
    .trn_done(trn_done), .cfg_err(cfg_err), .busy(busy)
);

// File: tb/sim_dma_seq_core.sv
`timescale 1ns/1ps
module sim_dma_seq_core;
    localparam real HALF = 2.5;
    localparam int  WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req = 1'b0;
    logic [31:0] frag_cfg = '0;
    logic [16:0] blk_len = '0;
    logic [27:0] trn_len = '0;
    logic [31:0] step_cfg = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] dst_lo = '0;
    logic [3:0]  src_hi = '0;
    logic [3:0]  dst_hi = '0;
    logic        beat_rdy = 1'b0;
    logic        beat_vld;
    logic [35:0] rd_addr, wr_addr;
    logic [1:0]  rd_size, wr_size;
    logic        beat_last, frag_done, blk_done, trn_done, cfg_err, busy;

    always #(HALF) clk = ~clk;

    dma_seq_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req),
        .frag_cfg(frag_cfg), .blk_len(blk_len), .trn_len(trn_len),
        .step_cfg(step_cfg), .src_lo(src_lo), .dst_lo(dst_lo),
        .src_hi(src_hi), .dst_hi(dst_hi), .beat_rdy(beat_rdy),
        .beat_vld(beat_vld), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .rd_size(rd_size), .wr_size(wr_size), .beat_last(beat_last),
        .frag_done(frag_done), .blk_done(blk_done), .trn_done(trn_done),
        .cfg_err(cfg_err), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;

    // configuration fields as the bench sees them
    int   c_sw, c_dw, c_mode, c_fsel, c_fen, c_frag;
    int   c_ss, c_ds;
    // model state
    logic [35:0] m_src, m_dst;
    int   m_f, m_b, m_t;
    bit   m_run;

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] make_frag(int sw, int dw, int sel, int en, int mode, int flen);
        return {sw[1:0], dw[1:0], 2'b00, mode[1:0], 2'b00, sel[0], en[0], 3'b000, flen[16:0]};
    endfunction

    task automatic apply_cfg(int sw, int dw, int mode, int sel, int en, int flen, int blen, int tlen,
                             int ss, int ds, logic [35:0] sa, logic [35:0] da);
        c_sw = sw; c_dw = dw; c_mode = mode; c_fsel = sel; c_fen = en; c_frag = flen;
        c_ss = ss; c_ds = ds;
        frag_cfg = make_frag(sw, dw, sel, en, mode, flen);
        blk_len  = 17'(blen);
        trn_len  = 28'(tlen);
        step_cfg = {ds[15:0], ss[15:0]};
        src_lo = sa[31:0]; src_hi = sa[35:32];
        dst_lo = da[31:0]; dst_hi = da[35:32];
    endtask

    function automatic bit cfg_bad();
        return (c_frag == 0) || (blk_len == 0) || (trn_len == 0) ||
               (c_sw == 3) || (c_dw == 3) || (c_mode == 3);
    endfunction

    task automatic cycle_check(bit rdy, bit rq, output bit unit_end, output bit t_end);
        int  bb;
        bit  fl, bl, tl, fe, be;
        unit_end = 0; t_end = 0;
        @(negedge clk);
        beat_rdy = rdy; req = rq;
        #1;
        if (m_run) begin
            bb = 1 << c_sw;
            check("R10", "beat_vld", 64'(beat_vld), 64'd1);
            check("R5", "rd_addr", 64'(rd_addr), 64'(m_src));
            check("R5", "wr_addr", 64'(wr_addr), 64'(m_dst));
            check("R4", "rd_size", 64'(rd_size), 64'(c_sw));
            check("R4", "wr_size", 64'(wr_size), 64'(c_dw));
            tl = (m_t <= bb);
            bl = (m_b <= bb) || tl;
            fl = (m_f <= bb) || bl;
            fe = fl; be = bl;
            check("R7", "beat_last", 64'(beat_last), 64'(fe));
            check("R7", "frag_done", 64'(frag_done), 64'(rdy && fe));
            check("R8", "blk_done", 64'(blk_done), 64'(rdy && be));
            check("R9", "trn_done", 64'(trn_done), 64'(rdy && tl));
            if (rdy) begin
                if (!(c_fen == 1 && c_fsel == 0)) m_src = m_src + 36'(c_ss);
                if (!(c_fen == 1 && c_fsel == 1)) m_dst = m_dst + 36'(c_ds);
                m_t = m_t - bb;
                m_b = be ? int'(blk_len) : m_b - bb;
                m_f = fe ? c_frag : m_f - bb;
                case (c_mode)
                    0: unit_end = fe;
                    1: unit_end = be;
                    default: unit_end = tl;
                endcase
                t_end = tl;
                if (unit_end || tl) m_run = 0;
            end
        end else begin
            check("R10", "idle beat_vld", 64'(beat_vld), 64'd0);
            check("R10", "idle done", 64'({frag_done, blk_done, trn_done}), 64'd0);
        end
    endtask

    // runs one configured job to the end; poke tries a start while busy (R2)
    task automatic run_job(bit poke);
        bit ue, te, done;
        int guard;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        #1;
        if (cfg_bad()) begin
            check("R3", "cfg_err", 64'(cfg_err), 64'd1);
            check("R3", "busy after bad cfg", 64'(busy), 64'd0);
            check("R3", "no beat after bad cfg", 64'(beat_vld), 64'd0);
            @(negedge clk); #1;
            check("R3", "cfg_err single pulse", 64'(cfg_err), 64'd0);
            check("R3", "still idle", 64'(beat_vld || busy), 64'd0);
            return;
        end
        check("R2", "cfg_err on good cfg", 64'(cfg_err), 64'd0);
        check("R2", "busy after load", 64'(busy), 64'd1);
        m_src = {src_hi, src_lo};
        m_dst = {dst_hi, dst_lo};
        m_f = c_frag; m_b = int'(blk_len); m_t = int'(trn_len);
        m_run = 0;
        done = 0; guard = 0;
        while (!done && guard < 400) begin
            repeat ($urandom % 3) cycle_check(1'($urandom), 1'b0, ue, te);
            if (poke) begin
                start = 1'b1; src_lo = ~src_lo; dst_lo = dst_lo ^ 32'h5a5a_0000;
                cycle_check(1'b0, 1'b0, ue, te);
                start = 1'b0; src_lo = ~src_lo; dst_lo = dst_lo ^ 32'h5a5a_0000;
                poke = 0;
            end
            cycle_check(1'($urandom), 1'b1, ue, te);
            m_run = 1;
            while (m_run && guard < 400) begin
                guard++;
                cycle_check(($urandom % 4) != 0, 1'($urandom), ue, te);
            end
            if (te) begin
                done = 1;
                cycle_check(1'b1, 1'b0, ue, te);
                check("R9", "busy after transaction", 64'(busy), 64'd0);
            end else begin
                cycle_check(1'b1, 1'b0, ue, te);
                check("R10", "waiting between units", 64'(busy), 64'd1);
            end
        end
        req = 1'b0;
    endtask

    task automatic random_job();
        int sw, dw, mode, fl, bl, tl;
        sw = ($urandom % 10 == 0) ? 3 : $urandom % 3;
        dw = ($urandom % 12 == 0) ? 3 : $urandom % 3;
        mode = ($urandom % 12 == 0) ? 3 : $urandom % 3;
        fl = ($urandom % 15 == 0) ? 0 : 1 + $urandom % 12;
        bl = ($urandom % 15 == 0) ? 0 : 1 + $urandom % 24;
        tl = ($urandom % 15 == 0) ? 0 : 1 + $urandom % 40;
        apply_cfg(sw, dw, mode, $urandom % 2, $urandom % 2, fl, bl, tl,
                  ($urandom % 2) ? $urandom % 16 : $urandom % 65536,
                  ($urandom % 2) ? $urandom % 16 : $urandom % 65536,
                  {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)});
        run_job(($urandom % 8) == 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ue, te;
        void'($urandom(32'd20240611));
        m_run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "busy", 64'(busy), 64'd0);
        check("R1", "beat_vld", 64'(beat_vld), 64'd0);
        check("R1", "pulses", 64'({beat_last, frag_done, blk_done, trn_done, cfg_err}), 64'd0);
        // R10 request while idle ignored
        cycle_check(1'b1, 1'b1, ue, te);
        cycle_check(1'b1, 1'b0, ue, te);
        check("R10", "req while idle", 64'(busy), 64'd0);

        // block mode, word beats, two blocks of two fragments
        apply_cfg(2, 2, 1, 0, 0, 8, 16, 32, 4, 4, 36'h0_1000_0000, 36'h2_2000_0000);
        run_job(1'b0);
        // fragment mode, one beat per fragment
        apply_cfg(2, 1, 0, 0, 0, 4, 8, 16, 4, 2, 36'h0_0000_0100, 36'h0_0000_0800);
        run_job(1'b0);
        // block shorter than fragment (R8), byte beats
        apply_cfg(0, 0, 0, 0, 0, 12, 8, 24, 1, 1, 36'h3_0000_0000, 36'h4_0000_0000);
        run_job(1'b0);
        // transaction not a multiple of the beat (R9)
        apply_cfg(2, 2, 2, 0, 0, 64, 64, 10, 4, 4, 36'h0_0000_0000, 36'h0_0000_0040);
        run_job(1'b0);
        // address wrap at 2^36 (R5)
        apply_cfg(2, 2, 2, 0, 0, 8, 16, 16, 8, 16, 36'hF_FFFF_FFF8, 36'hF_FFFF_FFF0);
        run_job(1'b0);
        // fixed source, then fixed destination (R6)
        apply_cfg(1, 1, 2, 0, 1, 4, 8, 12, 2, 2, 36'h0_4000_0000, 36'h0_5000_0000);
        run_job(1'b0);
        apply_cfg(1, 2, 1, 1, 1, 4, 8, 12, 2, 4, 36'h0_4000_0000, 36'h0_5000_0000);
        run_job(1'b0);
        // start while busy ignored (R2)
        apply_cfg(0, 0, 0, 0, 0, 2, 4, 8, 1, 3, 36'h1_0000_0010, 36'h1_0000_0020);
        run_job(1'b1);
        // each rejected configuration (R3)
        apply_cfg(2, 2, 1, 0, 0, 0, 8, 8, 4, 4, '0, '0); run_job(1'b0);
        apply_cfg(2, 2, 1, 0, 0, 4, 0, 8, 4, 4, '0, '0); run_job(1'b0);
        apply_cfg(2, 2, 1, 0, 0, 4, 8, 0, 4, 4, '0, '0); run_job(1'b0);
        apply_cfg(3, 2, 1, 0, 0, 4, 8, 8, 4, 4, '0, '0); run_job(1'b0);
        apply_cfg(2, 3, 1, 0, 0, 4, 8, 8, 4, 4, '0, '0); run_job(1'b0);
        apply_cfg(2, 2, 3, 0, 0, 4, 8, 8, 4, 4, '0, '0); run_job(1'b0);

        for (int i = 0; i < 300; i++) random_job();

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule